// File: doc/BRIEF.md
# Global Configuration and Stall Controller

This block takes commands from a host-side debug port and turns them into timed activity across an array of configurable tiles. Each command has a 5-bit opcode, a 32-bit address and a 32-bit data word, and it is presented with a one-cycle valid pulse. Tile accesses run on a simple configuration bus made of address, write data, a read strobe, a write strobe and read data. Each read or write strobe is stretched to a programmable number of cycles. The block also drives one stall line per clock domain and a global reset line.

The controller keeps a few small registers: a scratch test word, the stall mask, a clock-domain select bit, the strobe-length setting and a clock-switch delay bit. Each register has its own write and read opcodes. Read results, tile read data and a fixed bring-up signature come back to the host on a data port qualified by a one-cycle valid flag. Two timed commands stay busy for a command-given number of cycles. One releases stall on selected domains for a while. The other pulses the global reset.

Top module: `gcfg_ctrl`

## Requirements
- R1: After reset the stall outputs are all ones, the strobe length is 1, and the test word, clock-domain select and clock-switch delay bit are 0. The strobes, `glb_rst`, `busy` and `host_valid` are all low.
- R2: The signature opcode (3) gives `host_valid`=1 and `host_data`=0x0000A050 in the first cycle after the command is accepted.
- R3: A config write (opcode 1) with strobe length D holds `cfg_wr` high for cycles 1..D after acceptance and low in cycle D+1. `cfg_rd` stays low throughout. `cfg_addr` and `cfg_wdata` equal the command address and data in every one of those cycles.
- R4: A config read (opcode 2) with strobe length D holds `cfg_rd` high for cycles 1..D, with `cfg_addr` equal to the command address. In cycle D+1, `cfg_rd` is low, `host_valid` is 1 and `host_data` equals the `cfg_rdata` value sampled in cycle D.
- R5: Opcode 12 writes the strobe length from data bits [4:0] and opcode 13 reads it back. A written value of 0 is stored as 1. The stored value sets D for every later config read and write.
- R6: Opcode 7 loads the stall mask from data bits [NDOM-1:0], and the new mask is on `stall` in the first cycle after acceptance.
- R7: Clock advance (opcode 9) takes its domain mask from address bits [NDOM-1:0] and a duration N from data bits [7:0]. For cycles 1..N, each stall bit selected by the mask is 0 and every other bit keeps its mask value. In cycle N+1 the full saved mask is back on `stall`.
- R8: Global reset (opcode 6) with duration N from data bits [7:0] holds `glb_rst` high for cycles 1..N and low in cycle N+1. `busy` is low in that last cycle.
- R9: Each register returns its last written value one cycle after its read opcode. The register opcodes are test write 4 and read 5, stall read 8, clock-domain write 11 and read 10, and clock-switch delay write 14 and read 15. The clock-domain bit and the clock-switch delay bit take data bit 0 and also appear on `clk_sel` and `sw_dly_sel`.
- R10: `busy` is high from cycle 1 up to, but not including, the last cycle of a multi-cycle command. A command presented while `busy` is high has no effect.
- R11: The no-op opcode (0) and the opcodes 16..31 change no register and start no bus, stall or reset activity.
- R12: A duration of 0 for clock advance or global reset is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_op | input | 5 | Command opcode |
| cmd_addr | input | 32 | Command address / domain mask |
| cmd_data | input | 32 | Command data / duration |
| busy | output | 1 | Multi-cycle command in progress |
| host_data | output | 32 | Read result to the host |
| host_valid | output | 1 | host_data carries a new result this cycle |
| cfg_addr | output | 32 | Tile configuration address |
| cfg_wdata | output | 32 | Tile configuration write data |
| cfg_rd | output | 1 | Tile read strobe |
| cfg_wr | output | 1 | Tile write strobe |
| cfg_rdata | input | 32 | Tile read data |
| stall | output | NDOM | Per-domain stall lines |
| glb_rst | output | 1 | Global reset to the array |
| clk_sel | output | 1 | Clock-domain select bit |
| sw_dly_sel | output | 1 | Clock-switch delay select bit |

## Verification
The assertions check a number of local rules on every cycle. The signature word must appear one cycle after its opcode, and a read strobe must open in the first cycle. The write address and data must hold steady while the write strobe is high. When a read strobe falls, the sampled tile data must be delivered. The stall mask must be restored after an advance, the strobe-length register must never hold zero, and unknown opcodes must not disturb any register. Only the bench scenarios can show that the strobe and stall windows have the exact length chosen by the programmed settings and durations, including zero and the upper bounds. The same goes for commands dropped while the block is busy and for register read-back matching a model across random write sequences.

// File: rtl/gcfg_pkg.sv
package gcfg_pkg;

  localparam logic [4:0] OP_NOP      = 5'd0;
  localparam logic [4:0] OP_CFG_WR   = 5'd1;
  localparam logic [4:0] OP_CFG_RD   = 5'd2;
  localparam logic [4:0] OP_SIG      = 5'd3;
  localparam logic [4:0] OP_TEST_WR  = 5'd4;
  localparam logic [4:0] OP_TEST_RD  = 5'd5;
  localparam logic [4:0] OP_GRST     = 5'd6;
  localparam logic [4:0] OP_STALL_WR = 5'd7;
  localparam logic [4:0] OP_STALL_RD = 5'd8;
  localparam logic [4:0] OP_ADV      = 5'd9;
  localparam logic [4:0] OP_CDOM_RD  = 5'd10;
  localparam logic [4:0] OP_CDOM_WR  = 5'd11;
  localparam logic [4:0] OP_RWD_WR   = 5'd12;
  localparam logic [4:0] OP_RWD_RD   = 5'd13;
  localparam logic [4:0] OP_SWD_WR   = 5'd14;
  localparam logic [4:0] OP_SWD_RD   = 5'd15;

  localparam logic [31:0] SIG_WORD = 32'h0000_A050;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR,
    ST_RD,
    ST_ADV,
    ST_GRST,
    ST_TAIL
  } seq_st_t;

endpackage

// File: rtl/gcfg_regs.sv
module gcfg_regs
  import gcfg_pkg::*;
#(
  parameter int NDOM   = 4,
  parameter int TEST_W = 32,
  parameter int RW_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [4:0]        op,
  input  logic [TEST_W-1:0] w_test,
  input  logic [NDOM-1:0]   w_stall,
  input  logic [RW_W-1:0]   w_rwd,
  input  logic              w_bit,
  output logic [NDOM-1:0]   stall_mask,
  output logic [RW_W-1:0]   rwd,
  output logic              cdom,
  output logic              swd,
  output logic [31:0]       rd_word,
  output logic              rd_hit
);

  logic [TEST_W-1:0] test_q, test_d;
  logic [NDOM-1:0]   stall_q, stall_d;
  logic [RW_W-1:0]   rwd_q, rwd_d;
  logic              cdom_q, cdom_d;
  logic              swd_q, swd_d;
  logic              test_en, stall_en, rwd_en, cdom_en, swd_en;

  // write decode, one enable per register
  always_comb begin
    test_en  = we && (op == OP_TEST_WR);
    stall_en = we && (op == OP_STALL_WR);
    rwd_en   = we && (op == OP_RWD_WR);
    cdom_en  = we && (op == OP_CDOM_WR);
    swd_en   = we && (op == OP_SWD_WR);
    test_d   = w_test;
    stall_d  = w_stall;
    rwd_d    = (w_rwd == '0) ? RW_W'(1) : w_rwd;
    cdom_d   = w_bit;
    swd_d    = w_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_q  <= '0;
      stall_q <= '1;
      rwd_q   <= RW_W'(1);
      cdom_q  <= 1'b0;
      swd_q   <= 1'b0;
    end else begin
      if (test_en)  test_q  <= test_d;
      if (stall_en) stall_q <= stall_d;
      if (rwd_en)   rwd_q   <= rwd_d;
      if (cdom_en)  cdom_q  <= cdom_d;
      if (swd_en)   swd_q   <= swd_d;
    end
  end

  // read mux for single-cycle responses
  always_comb begin
    rd_word = '0;
    rd_hit  = 1'b1;
    case (op)
      OP_SIG:      rd_word = SIG_WORD;
      OP_TEST_RD:  rd_word[TEST_W-1:0] = test_q;
      OP_STALL_RD: rd_word[NDOM-1:0]   = stall_q;
      OP_CDOM_RD:  rd_word[0]          = cdom_q;
      OP_RWD_RD:   rd_word[RW_W-1:0]   = rwd_q;
      OP_SWD_RD:   rd_word[0]          = swd_q;
      default:     rd_hit = 1'b0;
    endcase
  end

  assign stall_mask = stall_q;
  assign rwd        = rwd_q;
  assign cdom       = cdom_q;
  assign swd        = swd_q;

  p_rwd_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rwd_q != '0);

  p_stall_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && op == OP_STALL_WR) |=> stall_q == $past(w_stall));

  p_unknown_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (op > OP_SWD_RD || op == OP_NOP)) |=>
      ($stable(test_q) && $stable(stall_q) && $stable(rwd_q) &&
       $stable(cdom_q) && $stable(swd_q)));

endmodule

// File: rtl/gcfg_seq.sv
module gcfg_seq
  import gcfg_pkg::*;
#(
  parameter int NDOM  = 4,
  parameter int RW_W  = 5,
  parameter int CNT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [4:0]      cmd_op,
  input  logic [31:0]     cmd_addr,
  input  logic [31:0]     cmd_data,
  input  logic [31:0]     cfg_rdata,
  input  logic [RW_W-1:0] rwd,
  input  logic [NDOM-1:0] stall_mask,
  input  logic [31:0]     rd_word,
  input  logic            rd_hit,
  output logic            accept,
  output logic            busy,
  output logic [31:0]     cfg_addr,
  output logic [31:0]     cfg_wdata,
  output logic            cfg_rd,
  output logic            cfg_wr,
  output logic [NDOM-1:0] stall,
  output logic            glb_rst,
  output logic [31:0]     host_data,
  output logic            host_valid
);

  localparam int CW = (RW_W > CNT_W) ? RW_W : CNT_W;

  seq_st_t         st_q, st_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic [31:0]     addr_q, addr_d;
  logic [31:0]     wd_q, wd_d;
  logic [NDOM-1:0] am_q, am_d;
  logic [31:0]     hd_q, hd_d;
  logic            hv_q, hv_d;
  logic [CNT_W-1:0] dur_raw;
  logic [CW-1:0]   dur;
  logic            last;

  assign busy    = (st_q != ST_IDLE) && (st_q != ST_TAIL);
  assign accept  = cmd_valid && !busy;
  assign dur_raw = cmd_data[CNT_W-1:0];
  assign dur     = (dur_raw == '0) ? CW'(1) : CW'(dur_raw);
  assign last    = (cnt_q == CW'(1));

  // next-state logic
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    am_d   = am_q;
    hd_d   = hd_q;
    hv_d   = 1'b0;

    case (st_q)
      ST_WR, ST_ADV, ST_GRST: begin
        if (last) st_d = ST_TAIL;
        else      cnt_d = cnt_q - CW'(1);
      end
      ST_RD: begin
        if (last) begin
          st_d = ST_TAIL;
          hd_d = cfg_rdata;
          hv_d = 1'b1;
        end else begin
          cnt_d = cnt_q - CW'(1);
        end
      end
      ST_TAIL: st_d = ST_IDLE;
      default: st_d = st_q;
    endcase

    if (accept) begin
      case (cmd_op)
        OP_CFG_WR: begin
          st_d   = ST_WR;
          cnt_d  = CW'(rwd);
          addr_d = cmd_addr;
          wd_d   = cmd_data;
        end
        OP_CFG_RD: begin
          st_d   = ST_RD;
          cnt_d  = CW'(rwd);
          addr_d = cmd_addr;
        end
        OP_ADV: begin
          st_d  = ST_ADV;
          cnt_d = dur;
          am_d  = cmd_addr[NDOM-1:0];
        end
        OP_GRST: begin
          st_d  = ST_GRST;
          cnt_d = dur;
        end
        default: begin
          st_d = ST_IDLE;
          if (rd_hit) begin
            hd_d = rd_word;
            hv_d = 1'b1;
          end
        end
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      addr_q <= '0;
      wd_q   <= '0;
      am_q   <= '0;
      hd_q   <= '0;
      hv_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
      am_q   <= am_d;
      hd_q   <= hd_d;
      hv_q   <= hv_d;
    end
  end

  // per-domain stall release during clock advance
  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    assign stall[g] = (st_q == ST_ADV && am_q[g]) ? 1'b0 : stall_mask[g];
  end

  assign cfg_addr   = addr_q;
  assign cfg_wdata  = wd_q;
  assign cfg_wr     = (st_q == ST_WR);
  assign cfg_rd     = (st_q == ST_RD);
  assign glb_rst    = (st_q == ST_GRST);
  assign host_data  = hd_q;
  assign host_valid = hv_q;

  p_sig_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == OP_SIG) |=> (host_valid && host_data == SIG_WORD));

  p_wr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> ($stable(cfg_addr) && $stable(cfg_wdata)));

  p_wr_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_wr) |-> (!busy && !cfg_rd));

  p_rd_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == OP_CFG_RD) |=> (cfg_rd && cfg_addr == $past(cmd_addr)));

  p_rd_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_rd) |-> (host_valid && host_data == $past(cfg_rdata)));

  p_adv_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ADV && last) |=> (stall == stall_mask));

  p_grst_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(glb_rst) |-> !busy);

endmodule

// File: rtl/gcfg_ctrl.sv
module gcfg_ctrl
  import gcfg_pkg::*;
#(
  parameter int NDOM   = 4,
  parameter int TEST_W = 32,
  parameter int RW_W   = 5,
  parameter int CNT_W  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [4:0]      cmd_op,
  input  logic [31:0]     cmd_addr,
  input  logic [31:0]     cmd_data,
  output logic            busy,
  output logic [31:0]     host_data,
  output logic            host_valid,
  output logic [31:0]     cfg_addr,
  output logic [31:0]     cfg_wdata,
  output logic            cfg_rd,
  output logic            cfg_wr,
  input  logic [31:0]     cfg_rdata,
  output logic [NDOM-1:0] stall,
  output logic            glb_rst,
  output logic            clk_sel,
  output logic            sw_dly_sel
);

  logic [1:0]      rst_sync_q;
  logic            rst_n_s;
  logic            accept;
  logic [NDOM-1:0] stall_mask;
  logic [RW_W-1:0] rwd;
  logic [31:0]     rd_word;
  logic            rd_hit;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  gcfg_regs #(
    .NDOM   (NDOM),
    .TEST_W (TEST_W),
    .RW_W   (RW_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .we         (accept),
    .op         (cmd_op),
    .w_test     (cmd_data[TEST_W-1:0]),
    .w_stall    (cmd_data[NDOM-1:0]),
    .w_rwd      (cmd_data[RW_W-1:0]),
    .w_bit      (cmd_data[0]),
    .stall_mask (stall_mask),
    .rwd        (rwd),
    .cdom       (clk_sel),
    .swd        (sw_dly_sel),
    .rd_word    (rd_word),
    .rd_hit     (rd_hit)
  );

  gcfg_seq #(
    .NDOM  (NDOM),
    .RW_W  (RW_W),
    .CNT_W (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_addr   (cmd_addr),
    .cmd_data   (cmd_data),
    .cfg_rdata  (cfg_rdata),
    .rwd        (rwd),
    .stall_mask (stall_mask),
    .rd_word    (rd_word),
    .rd_hit     (rd_hit),
    .accept     (accept),
    .busy       (busy),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_rd     (cfg_rd),
    .cfg_wr     (cfg_wr),
    .stall      (stall),
    .glb_rst    (glb_rst),
    .host_data  (host_data),
    .host_valid (host_valid)
  );

endmodule

// File: tb/tb_gcfg_ctrl.sv
module tb_gcfg_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NDOM = 4;

  logic            clk;
  logic            rst_n;
  logic            cmd_valid;
  logic [4:0]      cmd_op;
  logic [31:0]     cmd_addr;
  logic [31:0]     cmd_data;
  logic            busy;
  logic [31:0]     host_data;
  logic            host_valid;
  logic [31:0]     cfg_addr;
  logic [31:0]     cfg_wdata;
  logic            cfg_rd;
  logic            cfg_wr;
  logic [31:0]     cfg_rdata;
  logic [NDOM-1:0] stall;
  logic            glb_rst;
  logic            clk_sel;
  logic            sw_dly_sel;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model of the registers
  logic [31:0]     m_test;
  logic [NDOM-1:0] m_stall;
  logic [4:0]      m_rwd;
  logic            m_cdom;
  logic            m_swd;

  gcfg_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy),
    .host_data(host_data), .host_valid(host_valid), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
    .cfg_rdata(cfg_rdata), .stall(stall), .glb_rst(glb_rst),
    .clk_sel(clk_sel), .sw_dly_sel(sw_dly_sel)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [4:0] rwd_model(input logic [31:0] d);
    return (d[4:0] == 5'd0) ? 5'd1 : d[4:0];
  endfunction

  function automatic int dur_model(input logic [31:0] d);
    return (d[7:0] == 8'd0) ? 1 : int'(d[7:0]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [4:0] op, input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] op, input logic [31:0] exp, input string req);
    issue(op, 32'h0, 32'h0);
    check({req, " valid"}, 32'(host_valid), 32'd1);
    check({req, " data"}, host_data, exp);
  endtask

  task automatic read_all(input string req);
    reg_read(5'd5,  m_test, req);
    reg_read(5'd8,  32'(m_stall), req);
    reg_read(5'd13, 32'(m_rwd), req);
    reg_read(5'd10, 32'(m_cdom), req);
    reg_read(5'd15, 32'(m_swd), req);
  endtask

  task automatic set_rwd(input logic [31:0] d);
    issue(5'd12, 32'h0, d);
    m_rwd = rwd_model(d);
  endtask

  task automatic cfg_write(input logic [31:0] a, input logic [31:0] d);
    int dd = int'(m_rwd);
    issue(5'd1, a, d);
    for (int k = 1; k <= dd + 1; k++) begin
      check("R3 wr strobe", 32'(cfg_wr), 32'(k <= dd));
      check("R3 rd low", 32'(cfg_rd), 32'd0);
      check("R3 addr", cfg_addr, a);
      check("R3 data", cfg_wdata, d);
      check("R10 busy wr", 32'(busy), 32'(k <= dd));
      if (k <= dd) @(negedge clk);
    end
  endtask

  task automatic cfg_read(input logic [31:0] a, input logic [31:0] rd);
    int dd = int'(m_rwd);
    cfg_rdata = rd;
    issue(5'd2, a, 32'h0);
    for (int k = 1; k <= dd + 1; k++) begin
      check("R4 rd strobe", 32'(cfg_rd), 32'(k <= dd));
      check("R4 wr low", 32'(cfg_wr), 32'd0);
      if (k <= dd) check("R4 addr", cfg_addr, a);
      if (k == dd + 1) begin
        check("R4 host valid", 32'(host_valid), 32'd1);
        check("R4 host data", host_data, rd);
      end
      if (k <= dd) @(negedge clk);
    end
  endtask

  task automatic advance(input logic [NDOM-1:0] am, input logic [31:0] d, input string req);
    int n = dur_model(d);
    issue(5'd9, 32'(am), d);
    for (int k = 1; k <= n + 1; k++) begin
      if (k <= n) check(req, 32'(stall), 32'(m_stall & ~am));
      else        check({req, " restore"}, 32'(stall), 32'(m_stall));
      if (k <= n) @(negedge clk);
    end
  endtask

  task automatic grst(input logic [31:0] d, input string req);
    int n = dur_model(d);
    issue(5'd6, 32'h0, d);
    for (int k = 1; k <= n + 1; k++) begin
      check(req, 32'(glb_rst), 32'(k <= n));
      if (k == n + 1) check("R8 busy low at end", 32'(busy), 32'd0);
      if (k <= n) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    cmd_valid = 1'b0; cmd_op = '0; cmd_addr = '0; cmd_data = '0; cfg_rdata = '0;
    rst_n = 1'b0;
    m_test = '0; m_stall = '1; m_rwd = 5'd1; m_cdom = 1'b0; m_swd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1 stall", 32'(stall), 32'hF);
    check("R1 busy", 32'(busy), 32'd0);
    check("R1 strobes", 32'({cfg_wr, cfg_rd, glb_rst, host_valid}), 32'd0);
    check("R1 sel bits", 32'({clk_sel, sw_dly_sel}), 32'd0);
    read_all("R1 reset regs");

    // R2 signature
    issue(5'd3, 32'h0, 32'h0);
    check("R2 valid", 32'(host_valid), 32'd1);
    check("R2 word", host_data, 32'h0000A050);

    // R3/R4 at default length
    cfg_read(32'h1234_5678, 32'hCAFE_0001);
    cfg_write(32'h0000_00AA, 32'h5555_AAAA);

    // R5 length settings incl. zero
    set_rwd(32'h0);
    reg_read(5'd13, 32'd1, "R5 zero stored as one");
    set_rwd(32'd7);
    reg_read(5'd13, 32'd7, "R5 readback");
    cfg_write(32'hDEAD_0007, 32'h0BAD_F00D);
    cfg_read(32'hBEEF_0007, 32'h1357_9BDF);
    set_rwd(32'd20);
    cfg_write(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    cfg_read(32'h0000_0000, 32'hFFFF_0000);

    // R6 stall load visible next cycle
    issue(5'd7, 32'h0, 32'hA);
    m_stall = 4'hA;
    check("R6 stall next cycle", 32'(stall), 32'hA);
    reg_read(5'd8, 32'hA, "R6 stall readback");

    // R7 clock advance, R12 zero duration
    advance(4'b0110, 32'd5, "R7 adv partial");
    advance(4'hF, 32'd1, "R7 adv all one cycle");
    advance(4'b0011, 32'd0, "R12 adv zero");
    advance(4'b1001, 32'd100, "R7 adv long");

    // R8 global reset, R12 zero duration
    grst(32'd3, "R8 grst short");
    grst(32'd0, "R12 grst zero");
    grst(32'd100, "R8 grst long");

    // R9 register pairs, random values
    for (int i = 0; i < 40; i++) begin
      logic [31:0] v = $urandom;
      case ($urandom_range(0, 4))
        0: begin issue(5'd4, 32'h0, v); m_test = v; end
        1: begin issue(5'd7, 32'h0, v); m_stall = v[NDOM-1:0]; end
        2: set_rwd(32'(v[4:0]));
        3: begin issue(5'd11, 32'h0, v); m_cdom = v[0]; end
        default: begin issue(5'd14, 32'h0, v); m_swd = v[0]; end
      endcase
    end
    read_all("R9 random readback");
    check("R9 clk_sel pin", 32'(clk_sel), 32'(m_cdom));
    check("R9 sw_dly_sel pin", 32'(sw_dly_sel), 32'(m_swd));

    // R10 command while busy is dropped
    set_rwd(32'd6);
    issue(5'd1, 32'h10, 32'h20);
    cmd_valid = 1'b1; cmd_op = 5'd7; cmd_data = 32'h0; cmd_addr = 32'h0;
    @(negedge clk);
    cmd_op = 5'd4; cmd_data = 32'h7777_7777;
    @(negedge clk);
    cmd_valid = 1'b0;
    check("R10 wr still running", 32'(cfg_wr), 32'd1);
    check("R10 stall untouched", 32'(stall), 32'(m_stall));
    repeat (6) @(negedge clk);
    read_all("R10 regs after busy drop");

    // R11 no-op and unknown opcodes
    issue(5'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R11 nop quiet", 32'({cfg_wr, cfg_rd, glb_rst, host_valid, busy}), 32'd0);
    issue(5'd20, 32'hFFFF_FFFF, 32'h0);
    check("R11 op20 quiet", 32'({cfg_wr, cfg_rd, glb_rst, host_valid, busy}), 32'd0);
    issue(5'd31, 32'h0, 32'h0);
    check("R11 op31 stall", 32'(stall), 32'(m_stall));
    read_all("R11 regs unchanged");

    // random mixed tile traffic
    for (int i = 0; i < 12; i++) begin
      set_rwd(32'($urandom_range(1, 20)));
      if ($urandom_range(0, 1) == 0) cfg_write($urandom, $urandom);
      else                           cfg_read($urandom, $urandom);
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule